// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block derives the serial clock for an I2C controller from the peripheral clock. A prescaler first divides the peripheral clock by one plus a small divide setting. The result is an internal reference tick, which software keeps below 20 MHz. A second stage counts these ticks to form one SCL period. The period is 20 ticks, plus eight ticks for each step of a 6-bit gap setting, plus a compensation count. The compensation count covers the bus rise time, the fall time and the internal delay, which together come to about 285 ns of internal-clock time.

Software packs both settings into a single configuration word, with the gap field directly above the divide field. The width of the divide field is a parameter: 2 bits for one variant and 3 bits for the other. The word is written before each transfer. That write starts the generator, which always begins with the low half of a period. Clearing the enable stops the generator and releases SCL high. The byte-level protocol that uses the SCL waveform is outside this block.

Top module: `scl_rate_gen`

## Requirements
- R1: After reset, `scl_level` is 1 and `ref_tick` stays 0 until an enabled configuration write.
- R2: The configuration word carries the divide setting in bits [DIV_W-1:0] and the gap setting in bits [DIV_W+5:DIV_W].
- R3: While running, `ref_tick` pulses for one cycle every (1 + divide) clock cycles. The first pulse comes (1 + divide) cycles after the configuration write.
- R4: One SCL period lasts P = 20 + 8*gap + comp reference ticks, where comp is the value on `comp_cnt` at the time of the write.
- R5: Within a period, SCL is low for ceil(P/2) ticks and then high for floor(P/2) ticks. Each tick lasts (1 + divide) clock cycles.
- R6: A configuration write while `enable` is 1 starts the generator. `scl_level` is 0 from the next cycle, at the beginning of a low phase. A write while the generator is already running restarts the period with the new settings.
- R7: While `enable` is 0, `scl_level` is 1 and `ref_tick` is 0. Raising `enable` again without a new write leaves the generator stopped.
- R8: A configuration write while `enable` is 0 has no effect. It neither starts the generator nor is used afterwards.
- R9: With DIV_W = 3, divide settings up to 7 are honoured, and the gap field moves up by one bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Generator enable; when low, SCL is released and the counters are cleared |
| cfg_wr | input | 1 | Configuration write strobe; starts or restarts the generator |
| cfg_data | input | DIV_W+6 | Packed configuration word: gap above divide |
| comp_cnt | input | 4 | Compensation count in internal ticks, captured on write |
| ref_tick | output | 1 | Internal reference tick, one cycle wide |
| scl_level | output | 1 | SCL drive level (1 = released) |

## Verification
The bench goes after the odd period lengths. In these the low phase must take the extra tick, so a design that rounded the halves the wrong way would show low and high counts swapped by one tick. The largest gap and compensation combination checks the width of the period counter; a counter that is one bit too narrow would wrap and give a short period. A write in the middle of the high phase must restart at a low phase with the new length. A design that ignored the restart would finish the old period first. Dropping `enable` and raising it again without a write must leave SCL released, and so must a write made while disabled. A design that kept its armed state, or latched the stray write, would start clocking.

// File: rtl/scl_pkg.sv
package scl_pkg;

  localparam int unsigned SCL_BASE_TICKS = 20;
  localparam int unsigned SCL_GAP_STEP   = 8;

  function automatic int unsigned scl_max_period(int unsigned gap_w, int unsigned comp_w);
    return SCL_BASE_TICKS + SCL_GAP_STEP * ((1 << gap_w) - 1) + ((1 << comp_w) - 1);
  endfunction

endpackage

// File: rtl/scl_cfg_reg.sv
module scl_cfg_reg #(
  parameter int DIV_W  = 2,
  parameter int GAP_W  = 6,
  parameter int COMP_W = 4,
  localparam int CFG_W = DIV_W + GAP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cfg_wr,
  input  logic [CFG_W-1:0]  cfg_data,
  input  logic [COMP_W-1:0] comp_in,
  output logic [DIV_W-1:0]  div_q,
  output logic [GAP_W-1:0]  gap_q,
  output logic [COMP_W-1:0] comp_q,
  output logic              armed,
  output logic              restart
);

  logic [DIV_W-1:0]  div_n;
  logic [GAP_W-1:0]  gap_n;
  logic [COMP_W-1:0] comp_n;
  logic              armed_n;

  assign restart = enable & cfg_wr;

  always_comb begin
    div_n   = div_q;
    gap_n   = gap_q;
    comp_n  = comp_q;
    armed_n = armed;
    if (restart) begin
      div_n   = cfg_data[DIV_W-1:0];
      gap_n   = cfg_data[CFG_W-1:DIV_W];
      comp_n  = comp_in;
      armed_n = 1'b1;
    end else if (!enable) begin
      armed_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      gap_q  <= '0;
      comp_q <= '0;
      armed  <= 1'b0;
    end else begin
      div_q  <= div_n;
      gap_q  <= gap_n;
      comp_q <= comp_n;
      armed  <= armed_n;
    end
  end

  // R8: a write while disabled must not arm the generator
  a_r8_no_arm_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable) |=> !armed);

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_n;
  logic             at_end;

  assign at_end = (cnt_q == div);
  assign tick   = run & at_end;

  always_comb begin
    if (restart || !run || at_end) cnt_n = '0;
    else                           cnt_n = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  // R3: with a non-zero divide, two ticks never come back to back
  a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0 && !restart) |=> !tick);

  // R7: no tick while stopped
  a_r7_no_tick_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!run) |-> !tick);

endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr #(
  parameter int PER_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             tick,
  input  logic [PER_W-1:0] period,
  input  logic [PER_W-1:0] low_len,
  output logic             scl_level
);

  logic [PER_W-1:0] ph_q;
  logic [PER_W-1:0] ph_n;
  logic             wrap;

  assign wrap      = (ph_q == period - PER_W'(1));
  assign scl_level = !(run && (ph_q < low_len));

  always_comb begin
    if (restart || !run) ph_n = '0;
    else if (tick)       ph_n = wrap ? '0 : ph_q + PER_W'(1);
    else                 ph_n = ph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_n;
  end

  // R4: the phase index stays inside one period
  a_r4_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (ph_q < period));

  // R5: while running undisturbed, SCL only moves after a reference tick
  a_r5_edge_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(restart) && (scl_level != $past(scl_level)))
      |-> $past(tick));

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
  parameter int DIV_W  = 2,
  parameter int GAP_W  = 6,
  parameter int COMP_W = 4,
  localparam int CFG_W = DIV_W + GAP_W,
  localparam int PER_W = $clog2(scl_pkg::scl_max_period(GAP_W, COMP_W) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cfg_wr,
  input  logic [CFG_W-1:0]  cfg_data,
  input  logic [COMP_W-1:0] comp_cnt,
  output logic              ref_tick,
  output logic              scl_level
);

  logic [DIV_W-1:0]  div_q;
  logic [GAP_W-1:0]  gap_q;
  logic [COMP_W-1:0] comp_q;
  logic              armed;
  logic              restart;
  logic [PER_W-1:0]  period;
  logic [PER_W-1:0]  low_len;

  scl_cfg_reg #(.DIV_W(DIV_W), .GAP_W(GAP_W), .COMP_W(COMP_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_wr(cfg_wr),
    .cfg_data(cfg_data), .comp_in(comp_cnt),
    .div_q(div_q), .gap_q(gap_q), .comp_q(comp_q),
    .armed(armed), .restart(restart)
  );

  assign period  = PER_W'(scl_pkg::SCL_BASE_TICKS)
                 + PER_W'(scl_pkg::SCL_GAP_STEP * 32'(gap_q))
                 + PER_W'(comp_q);
  assign low_len = PER_W'((32'(period) + 32'd1) >> 1);

  scl_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(armed), .restart(restart),
    .div(div_q), .tick(ref_tick)
  );

  scl_phase_ctr #(.PER_W(PER_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .run(armed), .restart(restart),
    .tick(ref_tick), .period(period), .low_len(low_len),
    .scl_level(scl_level)
  );

  // R6: an enabled write opens a low phase on the next cycle
  a_r6_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !scl_level);

  // R7: SCL is released whenever the generator is stopped
  a_r7_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed) |-> scl_level);

endmodule

// File: tb/scl_rate_gen_test.sv
module scl_rate_gen_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       enable;
  logic       cfg_wr;
  logic [7:0] cfg2;
  logic [8:0] cfg3;
  logic [3:0] comp;
  logic       tick2, scl2, tick3, scl3;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  scl_rate_gen #(.DIV_W(2)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_wr(cfg_wr),
    .cfg_data(cfg2), .comp_cnt(comp), .ref_tick(tick2), .scl_level(scl2)
  );

  scl_rate_gen #(.DIV_W(3)) uut_w3 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_wr(cfg_wr),
    .cfg_data(cfg3), .comp_cnt(comp), .ref_tick(tick3), .scl_level(scl3)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic cur_scl(input bit sel);
    return sel ? scl3 : scl2;
  endfunction

  function automatic logic cur_tick(input bit sel);
    return sel ? tick3 : tick2;
  endfunction

  task automatic write_cfg(input int d, input int g, input int c);
    @(negedge clk);
    cfg2   = 8'((g << 2) | (d & 3));
    cfg3   = 9'((g << 3) | (d & 7));
    comp   = 4'(c);
    enable = 1'b1;
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    cfg2   = '1;
    cfg3   = '1;
    comp   = '1;
  endtask

  // observe one full period from the write; sel picks the instance
  task automatic run_period(input bit sel, input int d, input int g, input int c, input string tag);
    int p, lows, highs, ticks, first;
    p = 20 + 8 * g + c;
    write_cfg(d, g, c);
    chk(cur_scl(sel) == 1'b0, {tag, " R6 low at start"}, cur_scl(sel), 0);
    lows = 0; highs = 0; ticks = 0; first = 0;
    while (cur_scl(sel) == 1'b0 && lows < 5000) begin
      lows++;
      if (cur_tick(sel)) begin
        ticks++;
        if (first == 0) first = lows;
      end
      @(negedge clk);
    end
    while (cur_scl(sel) == 1'b1 && highs < 5000) begin
      highs++;
      if (cur_tick(sel)) ticks++;
      @(negedge clk);
    end
    chk(first == d + 1, {tag, " R3 first tick"}, first, d + 1);
    chk(lows == ((p + 1) / 2) * (d + 1), {tag, " R5 low clocks"}, lows, ((p + 1) / 2) * (d + 1));
    chk(highs == (p / 2) * (d + 1), {tag, " R5 high clocks"}, highs, (p / 2) * (d + 1));
    chk(ticks == p, {tag, " R4 ticks per period"}, ticks, p);
  endtask

  task automatic quiet_window(input int n, input string tag);
    int bad;
    bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (scl2 !== 1'b1 || tick2 !== 1'b0) bad++;
    end
    chk(bad == 0, tag, bad, 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; enable = 1'b0; cfg_wr = 1'b0;
    cfg2 = '0; cfg3 = '0; comp = '0;
    repeat (3) @(negedge clk);
    chk(scl2 == 1'b1 && tick2 == 1'b0, "R1 in reset", scl2, 1);
    rst_n = 1'b1;
    quiet_window(12, "R1 idle after reset");
  endtask

  task automatic t_restart;
    int lows;
    write_cfg(0, 0, 0);
    repeat (11) @(negedge clk);
    chk(scl2 == 1'b1, "R6 in high phase before rewrite", scl2, 1);
    write_cfg(0, 1, 0);
    chk(scl2 == 1'b0, "R6 rewrite restarts low", scl2, 0);
    lows = 0;
    while (scl2 == 1'b0 && lows < 5000) begin
      lows++;
      @(negedge clk);
    end
    chk(lows == 14, "R6 new low length", lows, 14);
  endtask

  task automatic t_disable;
    write_cfg(1, 0, 0);
    repeat (5) @(negedge clk);
    enable = 1'b0;
    quiet_window(30, "R7 released when disabled");
    @(negedge clk);
    enable = 1'b1;
    quiet_window(30, "R7 re-enable without write stays off");
    @(negedge clk);
    enable = 1'b0;
    cfg2 = 8'h04; comp = 4'h0;
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    enable = 1'b1;
    quiet_window(30, "R8 write while disabled ignored");
    enable = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    run_period(1'b0, 0, 0, 0, "R2 d0 g0 c0");
    run_period(1'b0, 3, 1, 5, "R2 d3 g1 c5");
    run_period(1'b0, 1, 63, 15, "R4 max d1 g63 c15");
    run_period(1'b0, 2, 4, 6, "R2 d2 g4 c6");
    run_period(1'b1, 5, 2, 3, "R9 w3 d5 g2 c3");
    run_period(1'b1, 7, 0, 1, "R9 w3 d7 g0 c1");
    t_restart();
    t_disable();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule